// File: doc/BRIEF.md
# DMA Channel Register Slice

This block is the register-facing half of one DMA channel. A 32-bit register bus that moves whole words reaches the channel's control/status word, its control-block pointer and a free debug word. Six read-only words show the control block that the transfer engine is working on. The transfer engine sits beside this block and owns the data path. It receives a one-cycle start request when software raises the channel's active bit. It reports progress back through an update port that can write the active, paused and end status bits, raise the interrupt flag, and load the six shown fields.

The control/status word mixes several kinds of bits. A fixed group of bits is plain read/write. The end and interrupt flags clear when software writes 1 to them. A top bit resets the channel and clears itself. An abort bit is accepted but does nothing. The channel interrupt line follows the interrupt flag. Whenever software clears that flag, a one-cycle strobe tells the global interrupt-status logic (outside this block) to drop the channel's bit. Accesses to offsets that hold no register return zero and change nothing, and they pulse an error-log strobe.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset every readable word is 0, and `irq`, `start_req`, `irq_status_clr`, `rd_valid` and `bad_access` are 0.
- R2: A write to offset 0x00 replaces the status bits selected by mask 0x30FF0001 (bit 0 active, bits 16..23, bits 28..29) with the written bits. Every other status bit keeps its value, apart from the clears in R3 to R5.
- R3: Writing 1 to status bit 31 first clears the whole status word and the control-block pointer (offset 0x04). It then applies R2. Bit 31 always reads 0. The write also pulses `irq_status_clr`.
- R4: Writing 1 to status bit 1 (end) clears it. Writing 0 leaves it unchanged.
- R5: Writing 1 to status bit 2 (interrupt) clears it, drops `irq` in the next cycle and pulses `irq_status_clr` for exactly one cycle. At all other times `irq` equals status bit 2.
- R6: A status write that takes bit 0 from 0 to 1 raises `start_req` for exactly one cycle, in the cycle after the write. A write that leaves bit 0 at 1 raises nothing.
- R7: Writing 1 to status bit 30 (abort) has no effect of its own, and bit 30 always reads 0.
- R8: Offset 0x04 (control-block pointer, also driven on `cb_addr`) and offset 0x20 (debug) are plain read/write words.
- R9: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C return the engine's info, source, destination, length, stride and next-block words. They load only on `eng_fld_we`, and bus writes to them are ignored.
- R10: Any access to an offset other than those in R2, R8 and R9 (unaligned offsets included) reads 0 and changes no state. It pulses `bad_access` for one cycle, in the cycle after the access.
- R11: `eng_st_we` loads status bits 0 (active), 4 (paused) and 1 (end), and `eng_irq_set` sets bit 2. When a status write lands in the same cycle, the write's effect wins for every bit it touches: bits in the R2 mask, end or interrupt bits written as 1, or all bits on a reset.
- R12: A read presents its data on `rd_data` with `rd_valid` high in the cycle after the request. The data is the state before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| bad_access | output | 1 | One-cycle strobe for an undefined offset |
| eng_st_we | input | 1 | Engine loads active, paused, end bits |
| eng_active | input | 1 | New active bit |
| eng_paused | input | 1 | New paused bit |
| eng_end | input | 1 | New end bit |
| eng_irq_set | input | 1 | Engine raises the interrupt flag |
| eng_fld_we | input | 1 | Engine loads the six control-block words |
| eng_info | input | 32 | Transfer info word |
| eng_src | input | 32 | Source address |
| eng_dst | input | 32 | Destination address |
| eng_len | input | 32 | Transfer length |
| eng_stride | input | 32 | 2D stride word |
| eng_next | input | 32 | Next control-block address |
| cb_addr | output | 32 | Control-block pointer for the engine |
| start_req | output | 1 | One-cycle start request to the engine |
| irq | output | 1 | Channel interrupt line |
| irq_status_clr | output | 1 | One-cycle clear for the global interrupt-status bit |

## Verification
Most bad internal state shows within two cycles. A wrongly held status bit is visible in the next read of offset 0x00, one cycle after the request. A bad edge detector shows as a missing or doubled `start_req` in the cycle right after the status write. A misordered clear/replace step or a lost priority against the engine shows as a wrong end, active or interrupt bit, and through `irq` in the cycle after the clash. Decode faults show as data leaking from an undefined offset, as a read-only word that changes after a write, or as a `bad_access` pulse that is missing or extra.

// File: rtl/dmacsr_pkg.sv
// Package: shared constants for the DMA channel register slice.
// Assumes a 32-bit word bus with byte offsets; only whole words are accessed.
package dmacsr_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Status word bit positions (software depends on these).
    localparam int BIT_ACT   = 0;
    localparam int BIT_END   = 1;
    localparam int BIT_INT   = 2;
    localparam int BIT_PAUSE = 4;
    localparam int BIT_ABORT = 30;
    localparam int BIT_RST   = 31;

    // Bits that a status write replaces outright.
    localparam word_t RW_MASK = 32'h30FF_0001;

    // Register offsets.
    localparam int OFS_CS     = 'h00;
    localparam int OFS_CB     = 'h04;
    localparam int OFS_MIR0   = 'h08;
    localparam int OFS_STEP   = 4;
    localparam int NUM_MIRROR = 6;
    localparam int OFS_DBG    = 'h20;
endpackage

// File: rtl/dmacsr_status.sv
// Module: control/status word of one channel.
// Applies engine updates first, then the bus write on top of them, so the
// bus wins for every bit it touches. Produces the start, irq and clear pulses.
// Assumes wr_en is already qualified to a status-word write.
module dmacsr_status
    import dmacsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wdata,
    input  logic  eng_st_we,
    input  logic  eng_active,
    input  logic  eng_paused,
    input  logic  eng_end,
    input  logic  eng_irq_set,
    output word_t cs_o,
    output logic  cb_clr_o,
    output logic  start_o,
    output logic  irq_o,
    output logic  int_clr_o
);
    word_t cs_q;
    word_t cs_d;
    logic  start_d;
    logic  int_clr_d;

    // Next status word: engine update, then bus clears, then masked replace.
    always_comb begin
        cs_d = cs_q;
        if (eng_st_we) begin
            cs_d[BIT_ACT]   = eng_active;
            cs_d[BIT_PAUSE] = eng_paused;
            cs_d[BIT_END]   = eng_end;
        end
        if (eng_irq_set) begin
            cs_d[BIT_INT] = 1'b1;
        end
        if (wr_en) begin
            if (wdata[BIT_RST]) cs_d = '0;
            if (wdata[BIT_END]) cs_d[BIT_END] = 1'b0;
            if (wdata[BIT_INT]) cs_d[BIT_INT] = 1'b0;
            cs_d = (cs_d & ~RW_MASK) | (wdata & RW_MASK);
        end
    end

    // Start on a software-driven rising edge of the active bit.
    assign start_d   = wr_en && !cs_q[BIT_ACT] && cs_d[BIT_ACT];
    assign int_clr_d = wr_en && (wdata[BIT_INT] || wdata[BIT_RST]);
    assign cb_clr_o  = wr_en && wdata[BIT_RST];

    // Status and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q      <= '0;
            start_o   <= 1'b0;
            int_clr_o <= 1'b0;
        end else begin
            cs_q      <= cs_d;
            start_o   <= start_d;
            int_clr_o <= int_clr_d;
        end
    end

    assign cs_o  = cs_q;
    assign irq_o = cs_q[BIT_INT];

    a_r2_mask_replace: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cs_q & RW_MASK) == ($past(wdata) & RW_MASK)));
    a_r3_reset_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[BIT_RST]) |=> ((cs_q & ~RW_MASK) == '0));
    a_r4_end_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[BIT_END]) |=> !cs_q[BIT_END]);
    a_r5_int_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[BIT_INT]) |=> (!irq_o && int_clr_o));
    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    a_r6_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> cs_q[BIT_ACT]);
    a_r7_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_q[BIT_ABORT] && !cs_q[BIT_RST]);
endmodule

// File: rtl/dmacsr_mirror.sv
// Module: read-only copy of the control block that the engine is working on.
// Loads all fields together on load_i; the bus cannot write here.
module dmacsr_mirror
    import dmacsr_pkg::*;
#(
    parameter int NFIELD = NUM_MIRROR
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [NFIELD-1:0][WORD_W-1:0] fields_i,
    output logic [NFIELD-1:0][WORD_W-1:0] fields_o
);
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        // One field register, loaded by the engine only.
        always_ff @(posedge clk) begin
            if (!rst_n)      fields_o[g] <= '0;
            else if (load_i) fields_o[g] <= fields_i[g];
        end
    end

    a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(fields_o));
endmodule

// File: rtl/dmacsr_bus.sv
// Module: offset decode, write qualifiers, registered read mux and
// the undefined-offset strobe. Assumes one whole-word access per cycle.
module dmacsr_bus
    import dmacsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  word_t                             cs_i,
    input  word_t                             cb_i,
    input  word_t                             dbg_i,
    input  logic [NUM_MIRROR-1:0][WORD_W-1:0] mir_i,
    output logic                              wr_cs_o,
    output logic                              wr_cb_o,
    output logic                              wr_dbg_o,
    output word_t                             rd_data_o,
    output logic                              rd_valid_o,
    output logic                              err_o
);
    localparam logic [ADDR_W-1:0] A_CS  = ADDR_W'(OFS_CS);
    localparam logic [ADDR_W-1:0] A_CB  = ADDR_W'(OFS_CB);
    localparam logic [ADDR_W-1:0] A_DBG = ADDR_W'(OFS_DBG);

    word_t rmux;
    logic  known;
    logic  do_wr;
    logic  do_rd;

    assign do_wr = req_valid && req_write;
    assign do_rd = req_valid && !req_write;

    // Decode the offset and select the read word; unknown offsets give 0.
    always_comb begin
        rmux  = '0;
        known = 1'b0;
        if (req_addr == A_CS) begin
            known = 1'b1;
            rmux  = cs_i;
        end
        if (req_addr == A_CB) begin
            known = 1'b1;
            rmux  = cb_i;
        end
        if (req_addr == A_DBG) begin
            known = 1'b1;
            rmux  = dbg_i;
        end
        for (int i = 0; i < NUM_MIRROR; i++) begin
            if (req_addr == ADDR_W'(OFS_MIR0 + OFS_STEP * i)) begin
                known = 1'b1;
                rmux  = mir_i[i];
            end
        end
    end

    assign wr_cs_o  = do_wr && (req_addr == A_CS);
    assign wr_cb_o  = do_wr && (req_addr == A_CB);
    assign wr_dbg_o = do_wr && (req_addr == A_DBG);

    // Registered read return and error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            rd_valid_o <= do_rd;
            err_o      <= req_valid && !known;
            if (do_rd) rd_data_o <= rmux;
        end
    end

    a_r10_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && err_o) |-> (rd_data_o == '0));
    a_r12_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(do_rd));
    a_r10_err_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_valid));
endmodule

// File: rtl/dma_chan_regs.sv
// Module: top of the per-channel DMA register slice.
// Holds the control-block pointer and debug word, and ties together the
// status word, the read-only mirror and the bus decode. Assumes the engine
// and the global interrupt/enable logic sit outside this block.
module dma_chan_regs
    import dmacsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              bad_access,
    input  logic              eng_st_we,
    input  logic              eng_active,
    input  logic              eng_paused,
    input  logic              eng_end,
    input  logic              eng_irq_set,
    input  logic              eng_fld_we,
    input  logic [31:0]       eng_info,
    input  logic [31:0]       eng_src,
    input  logic [31:0]       eng_dst,
    input  logic [31:0]       eng_len,
    input  logic [31:0]       eng_stride,
    input  logic [31:0]       eng_next,
    output logic [31:0]       cb_addr,
    output logic              start_req,
    output logic              irq,
    output logic              irq_status_clr
);
    word_t cs_w;
    word_t cb_q;
    word_t dbg_q;
    logic  wr_cs;
    logic  wr_cb;
    logic  wr_dbg;
    logic  cb_clr;
    logic [NUM_MIRROR-1:0][WORD_W-1:0] mir_in;
    logic [NUM_MIRROR-1:0][WORD_W-1:0] mir_q;

    // Field order matches the offset order 0x08 upward.
    assign mir_in = {eng_next, eng_stride, eng_len, eng_dst, eng_src, eng_info};

    dmacsr_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .cs_i       (cs_w),
        .cb_i       (cb_q),
        .dbg_i      (dbg_q),
        .mir_i      (mir_q),
        .wr_cs_o    (wr_cs),
        .wr_cb_o    (wr_cb),
        .wr_dbg_o   (wr_dbg),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .err_o      (bad_access)
    );

    dmacsr_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_cs),
        .wdata       (req_wdata),
        .eng_st_we   (eng_st_we),
        .eng_active  (eng_active),
        .eng_paused  (eng_paused),
        .eng_end     (eng_end),
        .eng_irq_set (eng_irq_set),
        .cs_o        (cs_w),
        .cb_clr_o    (cb_clr),
        .start_o     (start_req),
        .irq_o       (irq),
        .int_clr_o   (irq_status_clr)
    );

    dmacsr_mirror #(.NFIELD(NUM_MIRROR)) u_mirror (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (eng_fld_we),
        .fields_i (mir_in),
        .fields_o (mir_q)
    );

    // Pointer and debug words; channel reset clears the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_q  <= '0;
            dbg_q <= '0;
        end else begin
            if (cb_clr)     cb_q <= '0;
            else if (wr_cb) cb_q <= req_wdata;
            if (wr_dbg)     dbg_q <= req_wdata;
        end
    end

    assign cb_addr = cb_q;

    a_r3_pointer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cb_clr |=> (cb_addr == '0));
    a_r8_pointer_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cb |=> (cb_addr == $past(req_wdata)));
    a_r5_irq_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status_clr |=> !irq_status_clr || $past(wr_cs));
endmodule

// File: tb/dma_chan_regs_tb.sv
// Bench: directed corner cases plus seeded random register traffic,
// checked against a bench-side model built from the requirements.
module dma_chan_regs_tb;
    localparam int AW = 8;
    localparam logic [31:0] MASK = 32'h30FF_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic rd_valid, bad_access;
    logic eng_st_we = 1'b0, eng_active = 1'b0, eng_paused = 1'b0, eng_end = 1'b0;
    logic eng_irq_set = 1'b0, eng_fld_we = 1'b0;
    logic [31:0] eng_info = '0, eng_src = '0, eng_dst = '0, eng_len = '0;
    logic [31:0] eng_stride = '0, eng_next = '0;
    logic [31:0] cb_addr;
    logic start_req, irq, irq_status_clr;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m_cs = '0, m_cb = '0, m_dbg = '0;
    logic [31:0] m_mir [6];

    always #4 clk = ~clk;

    dma_chan_regs #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .bad_access(bad_access),
        .eng_st_we(eng_st_we), .eng_active(eng_active), .eng_paused(eng_paused),
        .eng_end(eng_end), .eng_irq_set(eng_irq_set), .eng_fld_we(eng_fld_we),
        .eng_info(eng_info), .eng_src(eng_src), .eng_dst(eng_dst),
        .eng_len(eng_len), .eng_stride(eng_stride), .eng_next(eng_next),
        .cb_addr(cb_addr), .start_req(start_req), .irq(irq),
        .irq_status_clr(irq_status_clr)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit defined(input logic [AW-1:0] a);
        return (a == 8'h00) || (a == 8'h04) || (a == 8'h20) ||
               (a >= 8'h08 && a <= 8'h1C && a[1:0] == 2'b00);
    endfunction

    // Expected status word from the rules in R2..R5 and R11.
    function automatic logic [31:0] f_cs(input logic [31:0] old, input logic [31:0] w,
                                         input bit wr, input bit est, input bit ea,
                                         input bit ep, input bit ee, input bit eirq);
        logic [31:0] n = old;
        if (est) begin n[0] = ea; n[4] = ep; n[1] = ee; end
        if (eirq) n[2] = 1'b1;
        if (wr) begin
            if (w[31]) n = '0;
            if (w[1]) n[1] = 1'b0;
            if (w[2]) n[2] = 1'b0;
            n = (n & ~MASK) | (w & MASK);
        end
        return n;
    endfunction

    function automatic logic [31:0] f_rd(input logic [AW-1:0] a);
        if (a == 8'h00) return m_cs;
        if (a == 8'h04) return m_cb;
        if (a == 8'h20) return m_dbg;
        if (defined(a)) return m_mir[(a - 8'h08) >> 2];
        return '0;
    endfunction

    // One cycle: optional bus write plus optional engine status update.
    task automatic cyc(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                       input bit est, input bit ea, input bit ep, input bit ee,
                       input bit eirq, input string req);
        bit wcs = wr && (a == 8'h00);
        logic [31:0] n = f_cs(m_cs, d, wcs, est, ea, ep, ee, eirq);
        bit e_start = wcs && !m_cs[0] && n[0];
        bit e_clr = wcs && (d[2] || d[31]);
        bit e_err = wr && !defined(a);
        @(negedge clk);
        req_valid = wr; req_write = wr; req_addr = a; req_wdata = d;
        eng_st_we = est; eng_active = ea; eng_paused = ep; eng_end = ee;
        eng_irq_set = eirq;
        @(posedge clk); #1;
        m_cs = n;
        if (wcs && d[31]) m_cb = '0;
        else if (wr && a == 8'h04) m_cb = d;
        if (wr && a == 8'h20) m_dbg = d;
        chk({31'b0, start_req}, {31'b0, e_start}, {req, " R6 start_req"});
        chk({31'b0, irq_status_clr}, {31'b0, e_clr}, {req, " R5 irq_status_clr"});
        chk({31'b0, bad_access}, {31'b0, e_err}, {req, " R10 bad_access"});
        chk({31'b0, irq}, {31'b0, m_cs[2]}, {req, " R5 irq follows flag"});
        @(negedge clk);
        req_valid = 0; req_write = 0; eng_st_we = 0; eng_irq_set = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string req);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        logic [31:0] e = f_rd(a);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk); #1;
        chk(rd_data, e, {req, " R12 rd_data"});
        chk({31'b0, rd_valid}, 32'd1, {req, " R12 rd_valid"});
        chk({31'b0, bad_access}, {31'b0, !defined(a)}, {req, " R10 strobe on read"});
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic load_fields(input logic [31:0] seed);
        @(negedge clk);
        eng_fld_we = 1;
        eng_info = seed ^ 32'h1; eng_src = seed ^ 32'h2; eng_dst = seed ^ 32'h3;
        eng_len = seed ^ 32'h4; eng_stride = seed ^ 32'h5; eng_next = seed ^ 32'h6;
        @(posedge clk); #1;
        for (int i = 0; i < 6; i++) m_mir[i] = seed ^ 32'(i + 1);
        @(negedge clk);
        eng_fld_we = 0;
    endtask

    initial begin : watchdog
        #(8 * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) m_mir[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({28'b0, start_req, irq, irq_status_clr, rd_valid}, 32'd0, "R1 outputs in reset");
        rst_n = 1;

        // R1: reset values of every word.
        for (int a = 0; a <= 8'h20; a += 4) rd(AW'(a), "R1 reset word");
        chk(cb_addr, 32'd0, "R1 cb_addr");

        // R3, R2, R6: all ones -> reset then masked replace; active rises.
        wr(8'h00, 32'hFFFF_FFFF, "R3 reset plus set");
        rd(8'h00, "R3 status after reset write");
        chk(m_cs, 32'h30FF_0001, "R2 model sanity");
        wr(8'h00, 32'h30FF_0001, "R6 no second start");

        // R8, R3: pointer and debug, then reset bit clears the pointer.
        wr(8'h04, 32'h1234_5670, "R8 pointer write");
        wr(8'h20, 32'hCAFE_F00D, "R8 debug write");
        rd(8'h04, "R8 pointer read");
        rd(8'h20, "R8 debug read");
        chk(cb_addr, 32'h1234_5670, "R8 cb_addr port");
        wr(8'h00, 32'h8000_0000, "R3 reset only");
        rd(8'h00, "R3 status zero");
        rd(8'h04, "R3 pointer zero");
        rd(8'h20, "R3 debug kept");

        // R11, R4, R5: engine sets bits, then software clears them.
        cyc(1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R11 engine set");
        rd(8'h00, "R11 engine bits visible");
        wr(8'h00, 32'h0000_0002, "R4 end clear");
        rd(8'h00, "R4 after end clear");
        wr(8'h00, 32'h0000_0000, "R4 zero leaves flags");
        rd(8'h00, "R4 flags kept");
        wr(8'h00, 32'h0000_0004, "R5 int clear");
        rd(8'h00, "R5 after int clear");

        // R7: abort bit does nothing.
        wr(8'h00, 32'h4003_0001, "R7 abort write");
        rd(8'h00, "R7 abort reads zero");

        // R9: mirrored fields load only from the engine.
        load_fields(32'hA5A5_0000);
        for (int a = 8'h08; a <= 8'h1C; a += 4) rd(AW'(a), "R9 mirror read");
        wr(8'h10, 32'hDEAD_BEEF, "R9 write to read-only");
        rd(8'h10, "R9 read-only unchanged");

        // R10: undefined offsets.
        rd(8'h24, "R10 undefined read");
        rd(8'h02, "R10 unaligned read");
        wr(8'h3C, 32'hFFFF_FFFF, "R10 undefined write");
        wr(8'h05, 32'hFFFF_FFFF, "R10 unaligned write");
        rd(8'h00, "R10 status unchanged");
        rd(8'h04, "R10 pointer unchanged");
        rd(8'h20, "R10 debug unchanged");

        // R11: clash, bus write wins for bits it touches.
        wr(8'h00, 32'h0000_0000, "R11 prep");
        cyc(1'b1, 8'h00, 32'h0000_0007, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R11 clash");
        rd(8'h00, "R11 clash result");
        cyc(1'b1, 8'h00, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R11 clash reset");
        rd(8'h00, "R11 reset beats engine");

        // Random traffic against the model.
        for (int k = 0; k < 400; k++) begin
            int op = $urandom % 4;
            logic [AW-1:0] a = AW'(($urandom % 18) * 4);
            logic [31:0] d = $urandom;
            if (($urandom % 8) == 0) a = AW'($urandom);
            if (($urandom % 4) != 0) d[31] = 1'b0;
            case (op)
                0: wr(a, d, "R2 random write");
                1: rd(a, "R12 random read");
                2: cyc(($urandom % 2) == 1, 8'h00, d, 1'b1, 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), "R11 random engine");
                default: if (($urandom % 8) == 0) load_fields($urandom);
                         else rd(8'h00, "R2 random status read");
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule